// File: doc/BRIEF.md
# Segmented Transfer Word-Count Accumulator

This block sits behind the header decoder of a multi-channel input path. Every header names an input channel and carries an 8-bit count field, a continuation flag and a completion flag. One header covers at most 256 data words. A channel whose data for one event is longer than that sends several headers. Each header except the last has its continuation flag set. The block joins those pieces back into one event, so that the event's words land as one contiguous block in memory.

The block keeps three things for each channel: whether an event is open, the base address of that event, and the running sum of the words already placed. For every header it reports where that segment's words go and how many there are. When a header arrives with the continuation flag clear, it also reports the complete event: its channel, its base address and its total length. The event can then be committed to a buffer. Moving the data words and choosing buffer space are handled elsewhere. The base address for a new event comes from an input port, sampled when the event's first header is accepted.

Top module: `seg_acc_top`

## Requirements
- R1: After reset, `seg_valid` and `done_valid` are low and every channel is closed, so the next header on any channel starts a new event.
- R2: A header accepted at a clock edge produces its outputs in the next cycle. `seg_valid` is high for exactly one cycle per header and stays low when no header was accepted.
- R3: `seg_len` equals the count field plus one. Field value 0 means 1 word, and 255 means 256 words.
- R4: A header for a closed channel opens an event. `seg_addr` equals `start_addr`, and that value is kept as the event's base address.
- R5: A header for a channel with an open event places its segment at the base address plus the sum of the earlier segments' lengths, modulo 2^ADDR_W. `start_addr` is ignored for that header.
- R6: A header with `hdr_cont` = 1 leaves the event open and adds its length to the running sum. Such a header never carries `hdr_done` = 1.
- R7: A header with `hdr_cont` = 0 ends the event. In the same cycle as its `seg_valid`, `done_valid` pulses with `done_chan`, `done_addr` = base address and `done_len` = the sum of all segment lengths. The channel is then closed.
- R8: A single header with `hdr_cont` = 0 on a closed channel is a whole event: `done_addr` = `start_addr` and `done_len` = count field + 1.
- R9: Each of the NUM_CH channels is tracked on its own. Headers on other channels that arrive between the segments of an event leave that event's base and sum unchanged.
- R10: On a final header (`hdr_cont` = 0), the value of `hdr_done` has no effect on any output.
- R11: `done_len` holds the total of MAX_SEGS full 256-word segments (4096 words with defaults) without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | A header is presented this cycle |
| hdr_chan | input | CH_W (4) | Channel the header belongs to |
| hdr_count | input | 8 | Segment length minus one |
| hdr_cont | input | 1 | Continuation: more headers follow for this event |
| hdr_done | input | 1 | Completion flag from the header source |
| start_addr | input | ADDR_W (16) | Base address offered for a new event |
| seg_valid | output | 1 | Segment placement valid |
| seg_chan | output | CH_W (4) | Channel of the segment |
| seg_addr | output | ADDR_W (16) | Destination address of the segment's first word |
| seg_len | output | 9 | Segment length in words (1..256) |
| done_valid | output | 1 | Event completed this cycle |
| done_chan | output | CH_W (4) | Channel of the completed event |
| done_addr | output | ADDR_W (16) | Base address of the completed event |
| done_len | output | SUM_W (13) | Total event length in words |

## Verification
The assertions assume that a header with the continuation flag set never also carries the completion flag. They also assume that no event spans more than MAX_SEGS headers, because the check that the running sum only grows relies on that bound. The scoreboard's stimulus follows both rules: it sets the completion flag only on final headers, and its random traffic forces the continuation flag clear once an event reaches its segment limit. Within those limits it interleaves channels, sends headers on consecutive cycles and lets addresses wrap past the top of the address space.

// File: rtl/seg_acc_pkg.sv
package seg_acc_pkg;
  // Width of the header count field; fixed by the header format.
  localparam int CNT_W   = 8;
  // Largest segment one header can describe.
  localparam int SEG_MAX = 1 << CNT_W;
  // Segment length is one more than the field, so one extra bit.
  localparam int LEN_W   = CNT_W + 1;

  function automatic logic [LEN_W-1:0] field_to_len(input logic [CNT_W-1:0] f);
    return {1'b0, f} + LEN_W'(1);
  endfunction
endpackage

// File: rtl/seg_acc_rst_sync.sv
module seg_acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/seg_acc_chan.sv
module seg_acc_chan #(
  parameter int ADDR_W = 16,
  parameter int SUM_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              hdr_cont,
  input  logic [ADDR_W-1:0] new_base,
  input  logic [SUM_W-1:0]  new_sum,
  output logic              open_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [SUM_W-1:0]  sum_o
);
  logic              open_q, open_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [SUM_W-1:0]  sum_q, sum_d;

  // Next state: a continuation keeps the event open with the grown sum,
  // a final header closes it and clears the sum.
  always_comb begin
    open_d = open_q;
    base_d = base_q;
    sum_d  = sum_q;
    if (upd_en) begin
      open_d = hdr_cont;
      base_d = new_base;
      sum_d  = hdr_cont ? new_sum : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      base_q <= '0;
      sum_q  <= '0;
    end else if (upd_en) begin
      open_q <= open_d;
      base_q <= base_d;
      sum_q  <= sum_d;
    end
  end

  assign open_o = open_q;
  assign base_o = base_q;
  assign sum_o  = sum_q;

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> ($stable(open_q) && $stable(base_q) && $stable(sum_q)));

  assert_close_on_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !hdr_cont) |=> (!open_q && sum_q == '0));

  assert_sum_grows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && hdr_cont && open_q) |=> (sum_q > $past(sum_q)));

  assert_base_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && hdr_cont && open_q) |=> (base_q == $past(base_q)));
endmodule

// File: rtl/seg_acc_calc.sv
module seg_acc_calc
  import seg_acc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SUM_W  = 13
) (
  input  logic              is_open,
  input  logic [ADDR_W-1:0] cur_base,
  input  logic [SUM_W-1:0]  cur_sum,
  input  logic [CNT_W-1:0]  hdr_count,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] base_eff,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic [SUM_W-1:0]  total
);
  logic [SUM_W-1:0] prior;

  always_comb begin
    prior    = is_open ? cur_sum : '0;
    base_eff = is_open ? cur_base : start_addr;
    seg_len  = field_to_len(hdr_count);
    seg_addr = base_eff + ADDR_W'(prior);
    total    = prior + SUM_W'(seg_len);
  end
endmodule

// File: rtl/seg_acc_top.sv
module seg_acc_top
  import seg_acc_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 16,
  parameter int MAX_SEGS = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SUM_W   = $clog2(MAX_SEGS * SEG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [CH_W-1:0]   hdr_chan,
  input  logic [CNT_W-1:0]  hdr_count,
  input  logic              hdr_cont,
  input  logic              hdr_done,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              seg_valid,
  output logic [CH_W-1:0]   seg_chan,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              done_valid,
  output logic [CH_W-1:0]   done_chan,
  output logic [ADDR_W-1:0] done_addr,
  output logic [SUM_W-1:0]  done_len
);
  logic rst_n_s;

  seg_acc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  // Per-channel state banks
  logic              ch_open [NUM_CH];
  logic [ADDR_W-1:0] ch_base [NUM_CH];
  logic [SUM_W-1:0]  ch_sum  [NUM_CH];

  logic              sel_open;
  logic [ADDR_W-1:0] sel_base;
  logic [SUM_W-1:0]  sel_sum;

  logic [ADDR_W-1:0] c_base_eff, c_seg_addr;
  logic [LEN_W-1:0]  c_seg_len;
  logic [SUM_W-1:0]  c_total;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_chan
      logic upd;
      assign upd = hdr_valid && (hdr_chan == CH_W'(g));
      seg_acc_chan #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) chan_i (
        .clk(clk), .rst_n(rst_n_s), .upd_en(upd), .hdr_cont(hdr_cont),
        .new_base(c_base_eff), .new_sum(c_total),
        .open_o(ch_open[g]), .base_o(ch_base[g]), .sum_o(ch_sum[g])
      );
    end
  endgenerate

  always_comb begin
    sel_open = 1'b0;
    sel_base = '0;
    sel_sum  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hdr_chan == CH_W'(i)) begin
        sel_open = ch_open[i];
        sel_base = ch_base[i];
        sel_sum  = ch_sum[i];
      end
    end
  end

  seg_acc_calc #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) calc_i (
    .is_open(sel_open), .cur_base(sel_base), .cur_sum(sel_sum),
    .hdr_count(hdr_count), .start_addr(start_addr),
    .base_eff(c_base_eff), .seg_addr(c_seg_addr),
    .seg_len(c_seg_len), .total(c_total)
  );

  // Output registers
  logic              sv_q, sv_d, dv_q, dv_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [ADDR_W-1:0] saddr_q, saddr_d, daddr_q, daddr_d;
  logic [LEN_W-1:0]  slen_q, slen_d;
  logic [SUM_W-1:0]  dlen_q, dlen_d;
  logic              out_en;

  always_comb begin
    out_en  = hdr_valid;
    sv_d    = hdr_valid;
    dv_d    = hdr_valid && !hdr_cont;
    chan_d  = hdr_chan;
    saddr_d = c_seg_addr;
    slen_d  = c_seg_len;
    daddr_d = c_base_eff;
    dlen_d  = c_total;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sv_q <= 1'b0;
      dv_q <= 1'b0;
    end else begin
      sv_q <= sv_d;
      dv_q <= dv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      chan_q  <= '0;
      saddr_q <= '0;
      slen_q  <= '0;
      daddr_q <= '0;
      dlen_q  <= '0;
    end else if (out_en) begin
      chan_q  <= chan_d;
      saddr_q <= saddr_d;
      slen_q  <= slen_d;
      daddr_q <= daddr_d;
      dlen_q  <= dlen_d;
    end
  end

  assign seg_valid  = sv_q;
  assign seg_chan   = chan_q;
  assign seg_addr   = saddr_q;
  assign seg_len    = slen_q;
  assign done_valid = dv_q;
  assign done_chan  = chan_q;
  assign done_addr  = daddr_q;
  assign done_len   = dlen_q;

  assert_ovf_hdr_no_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hdr_valid && hdr_cont) |-> !hdr_done);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hdr_valid |=> (!seg_valid && !done_valid));

  assert_done_with_seg_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_valid |-> (seg_valid && done_chan == seg_chan));

  assert_len_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    seg_valid |-> (seg_len >= LEN_W'(1) && seg_len <= LEN_W'(SEG_MAX)));

  assert_total_covers_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_valid |-> (done_len >= SUM_W'(seg_len)));
endmodule

// File: tb/seg_acc_top_tb_top.sv
module seg_acc_top_tb_top;
  localparam int CLK_P  = 10;
  localparam int NCH    = 16;
  localparam int AW     = 16;
  localparam int MSEG   = 16;
  localparam int CW     = 4;
  localparam int SW     = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [CW-1:0] hdr_chan = '0;
  logic [7:0] hdr_count = '0;
  logic hdr_cont = 1'b0;
  logic hdr_done = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic seg_valid, done_valid;
  logic [CW-1:0] seg_chan, done_chan;
  logic [AW-1:0] seg_addr, done_addr;
  logic [8:0] seg_len;
  logic [SW-1:0] done_len;

  always #(CLK_P/2) clk = ~clk;

  seg_acc_top #(.NUM_CH(NCH), .ADDR_W(AW), .MAX_SEGS(MSEG)) dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_chan(hdr_chan),
    .hdr_count(hdr_count), .hdr_cont(hdr_cont), .hdr_done(hdr_done),
    .start_addr(start_addr), .seg_valid(seg_valid), .seg_chan(seg_chan),
    .seg_addr(seg_addr), .seg_len(seg_len), .done_valid(done_valid),
    .done_chan(done_chan), .done_addr(done_addr), .done_len(done_len)
  );

  typedef struct {
    int    due;
    int    chan;
    int    addr;
    int    len;
    bit    fin;
    int    daddr;
    int    dlen;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit m_open [NCH];
  int m_base [NCH];
  int m_sum  [NCH];
  int m_nseg [NCH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // Driver: model the requirements, push the expectation, present the header.
  task automatic send(int ch, int cnt, bit cont, bit dn, int addr, string tag);
    exp_t e;
    if (!m_open[ch]) begin
      m_base[ch] = addr;  // R4
      m_sum[ch]  = 0;
      m_nseg[ch] = 0;
    end
    e.due  = cyc + 1;
    e.chan = ch;
    e.addr = (m_base[ch] + m_sum[ch]) & 16'hFFFF;  // R5
    e.len  = cnt + 1;                              // R3
    e.fin  = !cont;
    e.tag  = tag;
    m_sum[ch]  += cnt + 1;
    m_nseg[ch] += 1;
    e.daddr = m_base[ch];
    e.dlen  = m_sum[ch];
    m_open[ch] = cont;
    sb.push_back(e);
    hdr_valid  = 1'b1;
    hdr_chan   = CW'(ch);
    hdr_count  = 8'(cnt);
    hdr_cont   = cont;
    hdr_done   = dn;
    start_addr = AW'(addr);
    @(negedge clk);
    hdr_valid  = 1'b0;
    start_addr = AW'($urandom);
  endtask

  // Monitor: compare outputs against the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cyc > 4) begin
      if (seg_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R2 unexpected seg_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.due == cyc, "R2 latency", cyc, e.due);
          chk(int'(seg_chan) == e.chan, "R9 seg_chan", int'(seg_chan), e.chan);
          chk(int'(seg_addr) == e.addr, {e.tag, " seg_addr"}, int'(seg_addr), e.addr);
          chk(int'(seg_len) == e.len, "R3 seg_len", int'(seg_len), e.len);
          chk(done_valid == e.fin, {e.tag, " R7 done_valid"}, int'(done_valid), int'(e.fin));
          if (e.fin && done_valid) begin
            chk(int'(done_chan) == e.chan, "R7 done_chan", int'(done_chan), e.chan);
            chk(int'(done_addr) == e.daddr, {e.tag, " R7 done_addr"}, int'(done_addr), e.daddr);
            chk(int'(done_len) == e.dlen, {e.tag, " R11 done_len"}, int'(done_len), e.dlen);
          end
        end
      end else begin
        chk(!done_valid, "R2 done_valid without segment", int'(done_valid), 0);
      end
      if (sb.size() != 0 && sb[0].due < cyc) begin
        chk(0, "R2 missing segment", 0, sb[0].due);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_open[i] = 0; m_base[i] = 0; m_sum[i] = 0; m_nseg[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: quiet after reset
    chk(!seg_valid, "R1 seg_valid after reset", int'(seg_valid), 0);
    chk(!done_valid, "R1 done_valid after reset", int'(done_valid), 0);

    // R8: single-header event on a fresh channel (also R1: channel closed)
    send(0, 9, 0, 1, 16'h0100, "R8");
    @(negedge clk);

    // R6/R5/R7: split event with three pieces; later start_addr ignored
    send(1, 255, 1, 0, 16'h2000, "R4");
    send(1, 255, 1, 0, 16'h7777, "R5");
    send(1, 99,  0, 1, 16'h1234, "R7");
    @(negedge clk);

    // R9: interleaved channels
    send(2, 15, 1, 0, 16'h3000, "R4");
    send(3, 7,  1, 0, 16'h4000, "R4");
    send(2, 31, 1, 0, 16'h0000, "R9");
    send(3, 0,  0, 0, 16'h0000, "R9");
    @(negedge clk);
    send(2, 3,  0, 1, 16'h5555, "R9");
    @(negedge clk);

    // R11: MAX_SEGS full segments, base near top so addresses wrap (R5)
    for (int s = 0; s < MSEG - 1; s++) send(15, 255, 1, 0, 16'hF800, "R11");
    send(15, 255, 0, 1, 16'h0, "R11");
    @(negedge clk);

    // R10: the completion flag on final headers changes nothing
    send(4, 20, 1, 0, 16'hA000, "R10");
    send(4, 20, 0, 1, 16'h0, "R10");
    send(5, 20, 1, 0, 16'hA000, "R10");
    send(5, 20, 0, 0, 16'h0, "R10");
    send(6, 0, 0, 0, 16'hFFFF, "R10");
    send(6, 0, 0, 1, 16'hFFFF, "R10");
    @(negedge clk);

    // Random interleaved traffic
    for (int k = 0; k < 400; k++) begin
      int ch, cnt;
      bit cont;
      ch   = $urandom_range(NCH - 1);
      cnt  = $urandom_range(255);
      cont = $urandom_range(2) != 0;
      if (m_nseg[ch] >= MSEG - 1 && m_open[ch]) cont = 0;
      send(ch, cnt, cont, cont ? 1'b0 : 1'($urandom), int'($urandom) & 16'hFFFF,
           m_open[ch] ? "R5" : "R4");
      if ($urandom_range(3) == 0) @(negedge clk);
    end
    // close every open event
    for (int i = 0; i < NCH; i++) if (m_open[i]) send(i, 1, 0, 0, 0, "R7");
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule